// File: doc/BRIEF.md
# Serial Overhead Byte Output Port

This block takes the section overhead bytes that a receive framer extracts from each incoming frame. It sends them one at a time over a narrow serial port. Each transfer carries a 10-bit location code for the byte and then the 8-bit byte value. Each field goes out most significant bit first. Two strobes frame the transfer: one is high while the location bits are on the wire, and the other is high while the value bits are on the wire. A single quiet cycle separates the two fields.

Bytes enter through a small first-in first-out queue, so a burst from the framer is absorbed while earlier transfers drain. Most bytes pass through untouched. The framer flags the two parity bytes and supplies the parity it computed. For those bytes the block sends an error mask instead of the raw byte, in which every set bit marks a disagreeing bit position. A port enable gates the start of transfers. When the enable is low the port stays silent, and a transfer already in progress runs to its end.

Top module: `ohb_serial_tx`

## Requirements
- R1: For each transfer, the 10-bit location code is sent on `addr_o`, most significant bit first, one bit per cycle, while `ale` is high for exactly 10 consecutive cycles and `dle` is low.
- R2: After the last location bit, one cycle follows in which `ale`, `dle`, `addr_o` and `data_o` are all 0.
- R3: After that quiet cycle, the 8 value bits are sent on `data_o`, most significant bit first, while `dle` is high for exactly 8 consecutive cycles and `ale` is low.
- R4: A byte written with `in_is_par` = 0 is sent with its value equal to `in_data`. `in_exp_par` has no effect on it.
- R5: A byte written with `in_is_par` = 1 is sent with value `in_data` XOR `in_exp_par`. A 1 in this value marks an errored bit, and the value is all zeros when the two inputs agree.
- R6: While `port_en` is 0, no transfer starts and `ale` and `dle` stay low. Bytes written in that time are kept, and they are sent in arrival order once `port_en` returns to 1.
- R7: The queue holds FIFO_DEPTH bytes (default 4). A byte written when the queue is full is discarded and never sent. It sets `overflow` to 1, and `overflow` then stays 1 until reset.
- R8: One transfer spans 19 cycles. When another byte is waiting and the port is enabled, the next `ale` high cycle directly follows the last `dle` high cycle.
- R9: `addr_o` is 0 whenever `ale` is low, and `data_o` is 0 whenever `dle` is low.
- R10: If `port_en` falls during a transfer, that transfer completes unchanged and no further transfer starts until `port_en` is 1 again.
- R11: After reset, `ale`, `dle`, `addr_o`, `data_o` and `overflow` are 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; all logic on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Allows new transfers to start when 1 |
| in_valid | input | 1 | One overhead byte is presented this cycle |
| in_addr | input | 10 | Location code of the presented byte |
| in_data | input | 8 | Received byte value |
| in_is_par | input | 1 | 1 marks the byte as a parity byte |
| in_exp_par | input | 8 | Computed parity, used only for parity bytes |
| ale | output | 1 | High while location bits are sent |
| addr_o | output | 1 | Serial location bit |
| dle | output | 1 | High while value bits are sent |
| data_o | output | 1 | Serial value bit |
| overflow | output | 1 | Sticky flag for a byte lost to a full queue |

## Verification
The sequencer's bit counter controls both strobe lengths. A counter that is off by one shows up within a single transfer as a strobe that is one cycle too long or too short, or as a missing or doubled quiet cycle. Queue pointer faults appear as reordered, repeated or lost bytes in the first few transfers after a burst that is buffered while the port is disabled. A wrong mask path shows in the first parity byte as a nonzero value where the two inputs agree, or as a raw value. The bench sweeps location codes and values across their full range, covering the extremes.

// File: rtl/ohb_pkg.sv
package ohb_pkg;
  typedef enum logic [1:0] {
    SER_IDLE,
    SER_ADDR,
    SER_GAP,
    SER_DATA
  } ser_state_t;
endpackage

// File: rtl/ohb_mask.sv
// Value selection: parity bytes become an error mask, others pass through.
module ohb_mask #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              is_par,
  input  logic [DATA_W-1:0] exp_par,
  output logic [DATA_W-1:0] value
);
  always_comb begin
    if (is_par) value = raw ^ exp_par;
    else        value = raw;
  end
endmodule

// File: rtl/ohb_fifo.sv
// Simple queue; storage array has no reset so it maps onto RAM.
module ohb_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_wr, do_rd;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ohb_serializer.sv
// Transfer sequencer: address field, one quiet cycle, data field.
module ohb_serializer
  import ohb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              q_empty,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [DATA_W-1:0] head_data,
  output logic              pop,
  output logic              ale,
  output logic              addr_o,
  output logic              dle,
  output logic              data_o
);
  localparam int MAXW  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAXW);

  ser_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] ash;
  logic [DATA_W-1:0] dsh;
  logic              at_end;

  assign at_end = (state == SER_DATA) && (cnt == '0);
  assign pop    = en && !q_empty && ((state == SER_IDLE) || at_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SER_IDLE;
      cnt    <= '0;
      ash    <= '0;
      dsh    <= '0;
      ale    <= 1'b0;
      addr_o <= 1'b0;
      dle    <= 1'b0;
      data_o <= 1'b0;
    end else if (pop) begin
      state  <= SER_ADDR;
      ale    <= 1'b1;
      addr_o <= head_addr[ADDR_W-1];
      ash    <= {head_addr[ADDR_W-2:0], 1'b0};
      dsh    <= head_data;
      cnt    <= CNT_W'(ADDR_W - 1);
      dle    <= 1'b0;
      data_o <= 1'b0;
    end else begin
      case (state)
        SER_ADDR: begin
          if (cnt == '0) begin
            state  <= SER_GAP;
            ale    <= 1'b0;
            addr_o <= 1'b0;
          end else begin
            addr_o <= ash[ADDR_W-1];
            ash    <= {ash[ADDR_W-2:0], 1'b0};
            cnt    <= cnt - 1'b1;
          end
        end
        SER_GAP: begin
          state  <= SER_DATA;
          dle    <= 1'b1;
          data_o <= dsh[DATA_W-1];
          dsh    <= {dsh[DATA_W-2:0], 1'b0};
          cnt    <= CNT_W'(DATA_W - 1);
        end
        SER_DATA: begin
          if (cnt == '0) begin
            state  <= SER_IDLE;
            dle    <= 1'b0;
            data_o <= 1'b0;
          end else begin
            data_o <= dsh[DATA_W-1];
            dsh    <= {dsh[DATA_W-2:0], 1'b0};
            cnt    <= cnt - 1'b1;
          end
        end
        default: begin
          state  <= SER_IDLE;
          ale    <= 1'b0;
          addr_o <= 1'b0;
          dle    <= 1'b0;
          data_o <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ohb_serial_tx.sv
module ohb_serial_tx #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_is_par,
  input  logic [DATA_W-1:0] in_exp_par,
  output logic              ale,
  output logic              addr_o,
  output logic              dle,
  output logic              data_o,
  output logic              overflow
);
  localparam int ENTRY_W = ADDR_W + DATA_W;

  logic [DATA_W-1:0]  value;
  logic [ENTRY_W-1:0] head;
  logic               q_empty, q_full, pop;

  ohb_mask #(.DATA_W(DATA_W)) u_mask (
    .raw     (in_data),
    .is_par  (in_is_par),
    .exp_par (in_exp_par),
    .value   (value)
  );

  ohb_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (in_valid),
    .wr_data ({in_addr, value}),
    .rd_en   (pop),
    .rd_data (head),
    .empty   (q_empty),
    .full    (q_full)
  );

  ohb_serializer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .en        (port_en),
    .q_empty   (q_empty),
    .head_addr (head[ENTRY_W-1:DATA_W]),
    .head_data (head[DATA_W-1:0]),
    .pop       (pop),
    .ale       (ale),
    .addr_o    (addr_o),
    .dle       (dle),
    .data_o    (data_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                     overflow <= 1'b0;
    else if (in_valid && q_full) overflow <= 1'b1;
  end
endmodule

// File: rtl/ohb_serial_tx_chk.sv
module ohb_serial_tx_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rst,
  input logic port_en,
  input logic ale,
  input logic addr_o,
  input logic dle,
  input logic data_o,
  input logic overflow
);
  logic [7:0] ale_run, dle_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_run <= '0;
      dle_run <= '0;
    end else begin
      ale_run <= ale ? ale_run + 1'b1 : '0;
      dle_run <= dle ? dle_run + 1'b1 : '0;
    end
  end

  p_ale_len_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> (ale_run == 8'(ADDR_W)));
  p_gap_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> (!dle && !addr_o && !data_o));
  p_gap_then_data_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |=> dle);
  p_dle_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(dle) |-> (dle_run == 8'(DATA_W)));
  p_strobes_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(ale && dle));
  p_start_enabled_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |-> $past(port_en));
  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  p_addr_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !ale |-> !addr_o);
  p_data_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !dle |-> !data_o);
endmodule

bind ohb_serial_tx ohb_serial_tx_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .port_en  (port_en),
  .ale      (ale),
  .addr_o   (addr_o),
  .dle      (dle),
  .data_o   (data_o),
  .overflow (overflow)
);

// File: tb/tb_ohb_serial_tx.sv
`timescale 1ns/1ps
module tb_ohb_serial_tx;
  logic       clk = 1'b0;
  logic       rst;
  logic       port_en;
  logic       in_valid;
  logic [9:0] in_addr;
  logic [7:0] in_data;
  logic       in_is_par;
  logic [7:0] in_exp_par;
  logic       ale, addr_o, dle, data_o, overflow;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ohb_serial_tx dut (
    .clk(clk), .rst(rst), .port_en(port_en), .in_valid(in_valid),
    .in_addr(in_addr), .in_data(in_data), .in_is_par(in_is_par),
    .in_exp_par(in_exp_par), .ale(ale), .addr_o(addr_o), .dle(dle),
    .data_o(data_o), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] a, input logic [7:0] d, input logic par,
                      input logic [7:0] e);
    in_valid = 1'b1; in_addr = a; in_data = d; in_is_par = par; in_exp_par = e;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Receives one transfer from the ports; drop_at >= 0 lowers port_en mid-address.
  task automatic get_frame(input int drop_at, output logic [9:0] a, output logic [7:0] d);
    int  w = 0;
    bit  bad_a = 0, bad_g = 0, bad_d = 0, bad_z = 0;
    a = '0; d = '0;
    while (!ale && w < 200) begin @(negedge clk); w++; end
    if (!ale) begin chk(0, "R8 transfer never started", 0, 1); return; end
    for (int i = 0; i < 10; i++) begin
      if (!ale || dle) bad_a = 1;
      if (data_o) bad_z = 1;
      a = {a[8:0], addr_o};
      if (i == drop_at) port_en = 1'b0;
      @(negedge clk);
    end
    bad_g = ale || dle || addr_o || data_o;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (!dle || ale) bad_d = 1;
      if (addr_o) bad_z = 1;
      d = {d[6:0], data_o};
      if (i < 7) @(negedge clk);
    end
    chk(!bad_a, "R1 ale high for 10 address bits", bad_a, 0);
    chk(!bad_g, "R2 quiet cycle after address", bad_g, 0);
    chk(!bad_d, "R3 dle high for 8 data bits", bad_d, 0);
    chk(!bad_z, "R9 idle serial line at zero", bad_z, 0);
  endtask

  task automatic quiet(input int n, input string tag);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ale || dle || addr_o || data_o) bad = 1;
    end
    chk(!bad, tag, bad, 0);
  endtask

  initial begin
    wait (cyc == 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [9:0] ra, ea [8];
    logic [7:0] rd, ed [8];
    rst = 1'b1; port_en = 1'b0; in_valid = 1'b0;
    in_addr = '0; in_data = '0; in_is_par = 1'b0; in_exp_par = '0;
    repeat (4) @(negedge clk);
    chk({ale, dle, addr_o, data_o, overflow} == 5'b0, "R11 reset outputs",
        {ale, dle, addr_o, data_o, overflow}, 0);
    rst = 1'b0;
    @(negedge clk);
    quiet(10, "R11 queue empty after reset");

    // Plain bytes across the address and value range (R1 R3 R4)
    port_en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      logic [9:0] a;
      logic [7:0] d;
      a = (k == 0) ? 10'h000 : (k == 1) ? 10'h3FF : 10'((k * 97 + 5) % 1024);
      d = 8'((k * 53 + 11) % 256);
      push(a, d, 1'b0, ~d);
      get_frame(-1, ra, rd);
      chk(ra == a, "R1 address MSB first", ra, a);
      chk(rd == d, "R4 plain byte unchanged", rd, d);
      @(negedge clk);
      chk(!ale && !dle, "R8 port idles when queue empty", ale, 0);
    end

    // Parity bytes become error masks (R5)
    for (int k = 0; k < 24; k++) begin
      logic [7:0] d, e;
      d = 8'((k * 29 + 3) % 256);
      e = (k == 0) ? d : 8'((k * 71 + 1) % 256);
      push(10'(k * 41), d, 1'b1, e);
      get_frame(-1, ra, rd);
      chk(rd == (d ^ e), "R5 parity error mask", rd, d ^ e);
      @(negedge clk);
    end

    // Disabled port holds bytes, then sends back to back (R6 R8)
    port_en = 1'b0;
    ea[0] = 10'h001; ed[0] = 8'hA5;
    ea[1] = 10'h2AA; ed[1] = 8'h3C ^ 8'h0F;
    ea[2] = 10'h155; ed[2] = 8'h80;
    push(ea[0], 8'hA5, 1'b0, 8'h00);
    push(ea[1], 8'h3C, 1'b1, 8'h0F);
    push(ea[2], 8'h80, 1'b0, 8'hFF);
    quiet(40, "R6 no transfer while disabled");
    port_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      get_frame(-1, ra, rd);
      chk(ra == ea[k] && rd == ed[k], "R6 held bytes sent in order",
          {ra, rd}, {ea[k], ed[k]});
      @(negedge clk);
      if (k < 2) chk(ale, "R8 next transfer right after last data bit", ale, 1);
      else       chk(!ale, "R8 no extra transfer", ale, 0);
    end

    // Queue full: fifth byte dropped, overflow sticky (R7)
    port_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      ea[k] = 10'(100 + k * 200); ed[k] = 8'(k * 60 + 7);
      push(ea[k], ed[k], 1'b0, 8'h00);
    end
    chk(!overflow, "R7 no overflow at exactly full", overflow, 0);
    push(10'h3EE, 8'hEE, 1'b0, 8'h00);
    chk(overflow, "R7 overflow on write to full queue", overflow, 1);
    port_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      get_frame(-1, ra, rd);
      chk(ra == ea[k] && rd == ed[k], "R7 queued bytes kept in order",
          {ra, rd}, {ea[k], ed[k]});
    end
    quiet(40, "R7 dropped byte never sent");
    chk(overflow, "R7 overflow stays set", overflow, 1);

    // Enable dropped mid-transfer (R10)
    port_en = 1'b0;
    push(10'h123, 8'h5A, 1'b0, 8'h00);
    push(10'h321, 8'hC3, 1'b0, 8'h00);
    port_en = 1'b1;
    get_frame(3, ra, rd);
    chk(ra == 10'h123 && rd == 8'h5A, "R10 running transfer completes",
        {ra, rd}, {10'h123, 8'h5A});
    quiet(40, "R10 no new transfer after disable");
    port_en = 1'b1;
    get_frame(-1, ra, rd);
    chk(ra == 10'h321 && rd == 8'hC3, "R10 pending byte sent after re-enable",
        {ra, rd}, {10'h321, 8'hC3});

    // Reset clears the sticky flag (R11)
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!overflow, "R11 reset clears overflow", overflow, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule